// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains the singly linked list of extended capability headers kept in a 4 KB configuration space. The space lives in an external synchronous RAM organised as 32-bit words. The block reaches it through a single read/write port, and a read returns its data one cycle after it is issued. Each header word carries three fields: an identifier, a version and a byte pointer to the following header. A pointer of zero ends the list.

A lookup command names an identifier. The block follows the pointers from the list head at byte 0x100 until the identifier matches or the list ends. It then reports whether the identifier was found, the offset of the matching header, and the offset of the header visited before it.

An insert command places a new header at a given offset. At the head location, the existing pointer is preserved. Anywhere else, the block walks to the last node, rewrites only that node's pointer field, and writes the new header with a zero pointer. Malformed pointers, runaway loops and illegal insert arguments end the command with an error flag. Commands that arrive while the block is working are dropped.

Top module: `cap_chain_walker`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `mem_en` are low until a command arrives.
- R2: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A lookup starts at byte 0x100. On a match it reports `found`=1, `res_off` set to the header's offset, and `res_prev` set to the offset visited before it (0 when the match is the head).
- R3: If the word at byte 0x100 is all zero, a lookup reports `found`=0, `res_off`=0 and `res_prev`=0.
- R4: A lookup that reaches a header with a zero next field, without a match, reports `found`=0, `res_off`=0 and `res_prev` set to that last header's offset.
- R5: `done` is a one-cycle pulse and `busy` is low while it is high. For a command that reads k headers and writes nothing, `done` rises 2k clock edges after the edge that accepted the command.
- R6: A next offset that is not a multiple of 4, is below 0x100 or is above 0xFF8 ends the command with `err`=1 and `found`=0, and nothing is written.
- R7: Following a pointer away from the HOP_LIMIT-th header read is an error (`err`=1). A list of exactly HOP_LIMIT headers is walked without error.
- R8: An insert at an offset other than 0x100 changes only bits 31:20 of the last header, setting them to the new offset. It writes {next=0, version, identifier} at the new offset, reports `res_prev` set to the last header's offset, and raises `done` 2k+2 edges after acceptance.
- R9: An insert at 0x100 rewrites the head word with the new identifier and version but keeps its existing next field. `done` rises 3 edges after acceptance.
- R10: An insert whose size is below 8, whose offset is below 0x100 or not a multiple of 4, or whose offset plus size exceeds 4096 ends with `err`=1 in the edge of acceptance (`done` visible right after it), and nothing is written.
- R11: `cmd_valid` is ignored while `busy` is high: the ignored command causes no write and does not change the results of the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_append | input | 1 | 1 = insert, 0 = lookup |
| cmd_id | input | 16 | Capability identifier |
| cmd_ver | input | 4 | Version for inserts |
| cmd_off | input | 12 | Byte offset for inserts |
| cmd_size | input | 13 | Byte size for inserts |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup matched |
| err | output | 1 | Command ended in error |
| res_off | output | 12 | Matching (or inserted) offset |
| res_prev | output | 12 | Predecessor / last node offset |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after the read |

## Verification
The bench keeps the full 4 KB space (CFG_BYTES = 4096, LIST_BASE = 0x100), so the boundary inserts ending at byte 4096 and the pointer limits 0xFF8/0xFFC are exercised as in use. HOP_LIMIT is lowered to 6. With that value, a six-node list that must pass, a seven-node list and a self-referencing head that must fail all fit in a few dozen cycles. With the default limit, loop detection would take close to a thousand cycles per case.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;
  localparam int unsigned ID_W  = 16;
  localparam int unsigned VER_W = 4;
  localparam int unsigned PTR_W = 12;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } cap_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_PATCH,
    ST_NEWHDR
  } walk_state_e;
endpackage

// File: rtl/cap_ptr_check.sv
module cap_ptr_check
  import cap_walk_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 4096,
  parameter int unsigned LIST_BASE = 256
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             ptr_ok
);
  localparam int unsigned LAST_HDR = CFG_BYTES - 8;

  always_comb begin
    ptr_ok = (ptr[1:0] == 2'b00) &&
             (ptr >= PTR_W'(LIST_BASE)) &&
             (ptr <= PTR_W'(LAST_HDR));
  end
endmodule

// File: rtl/cap_append_check.sv
module cap_append_check
  import cap_walk_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 4096,
  parameter int unsigned LIST_BASE = 256
) (
  input  logic [PTR_W-1:0] off,
  input  logic [PTR_W:0]   size,
  output logic             args_ok
);
  localparam int unsigned SUM_W = PTR_W + 2;

  logic [SUM_W-1:0] end_b;

  always_comb begin
    end_b   = {2'b00, off} + {1'b0, size};
    args_ok = (size >= (PTR_W+1)'(8)) &&
              (off >= PTR_W'(LIST_BASE)) &&
              (off[1:0] == 2'b00) &&
              (end_b <= SUM_W'(CFG_BYTES));
  end
endmodule

// File: rtl/cap_hop_counter.sv
module cap_hop_counter #(
  parameter int unsigned HOP_LIMIT = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned HOP_W = $clog2(HOP_LIMIT + 1);

  logic [HOP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == HOP_W'(HOP_LIMIT));
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
  import cap_walk_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 4096,
  parameter int unsigned LIST_BASE = 256,
  parameter int unsigned HOP_LIMIT = (CFG_BYTES - LIST_BASE) / 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic                           cmd_append,
  input  logic [ID_W-1:0]                cmd_id,
  input  logic [VER_W-1:0]               cmd_ver,
  input  logic [PTR_W-1:0]               cmd_off,
  input  logic [PTR_W:0]                 cmd_size,
  output logic                           busy,
  output logic                           done,
  output logic                           found,
  output logic                           err,
  output logic [PTR_W-1:0]               res_off,
  output logic [PTR_W-1:0]               res_prev,
  output logic                           mem_en,
  output logic                           mem_we,
  output logic [$clog2(CFG_BYTES)-3:0]   mem_addr,
  output logic [31:0]                    mem_wdata,
  input  logic [31:0]                    mem_rdata
);
  localparam int unsigned AW  = $clog2(CFG_BYTES) - 2;
  localparam int unsigned LOW = ID_W + VER_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  walk_state_e      state_q, state_d;
  logic [PTR_W-1:0] cur_q, cur_d, prev_q, prev_d;
  logic [PTR_W-1:0] off_q, new_nxt_q, new_nxt_d;
  logic [LOW-1:0]   tail_low_q, tail_low_d;
  logic [ID_W-1:0]  id_q;
  logic [VER_W-1:0] ver_q;
  logic             app_q;
  logic             load_cmd;
  logic             done_q, done_d, found_q, found_d, err_q, err_d;
  logic [PTR_W-1:0] roff_q, roff_d, rprev_q, rprev_d;
  logic             hop_clr, hop_inc, hop_at_limit;
  logic             nxt_ok, args_ok;
  logic [ID_W-1:0]  rd_id;
  logic [PTR_W-1:0] rd_nxt;
  cap_hdr_t         wr_hdr;

  assign rd_id  = mem_rdata[ID_W-1:0];
  assign rd_nxt = mem_rdata[31:LOW];

  cap_ptr_check #(.CFG_BYTES(CFG_BYTES), .LIST_BASE(LIST_BASE)) u_ptr_chk (
    .ptr    (rd_nxt),
    .ptr_ok (nxt_ok)
  );

  cap_append_check #(.CFG_BYTES(CFG_BYTES), .LIST_BASE(LIST_BASE)) u_arg_chk (
    .off     (cmd_off),
    .size    (cmd_size),
    .args_ok (args_ok)
  );

  cap_hop_counter #(.HOP_LIMIT(HOP_LIMIT)) u_hops (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (hop_clr),
    .inc      (hop_inc),
    .at_limit (hop_at_limit)
  );

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    prev_d     = prev_q;
    new_nxt_d  = new_nxt_q;
    tail_low_d = tail_low_q;
    load_cmd   = 1'b0;
    done_d     = 1'b0;
    found_d    = found_q;
    err_d      = err_q;
    roff_d     = roff_q;
    rprev_d    = rprev_q;
    hop_clr    = 1'b0;
    hop_inc    = 1'b0;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_q[AW+1:2];
    wr_hdr     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          hop_clr  = 1'b1;
          cur_d    = PTR_W'(LIST_BASE);
          prev_d   = '0;
          if (cmd_append && !args_ok) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            found_d = 1'b0;
            roff_d  = cmd_off;
            rprev_d = '0;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        mem_en  = 1'b1;
        hop_inc = 1'b1;
        state_d = ST_EVAL;
      end
      ST_EVAL: begin
        found_d = 1'b0;
        err_d   = 1'b0;
        if (app_q && off_q == PTR_W'(LIST_BASE)) begin
          new_nxt_d = rd_nxt;
          rprev_d   = '0;
          state_d   = ST_NEWHDR;
        end else if (!app_q && cur_q == PTR_W'(LIST_BASE) && mem_rdata == '0) begin
          roff_d  = '0;
          rprev_d = '0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!app_q && rd_id == id_q) begin
          found_d = 1'b1;
          roff_d  = cur_q;
          rprev_d = prev_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (rd_nxt == '0) begin
          rprev_d = cur_q;
          if (app_q) begin
            tail_low_d = mem_rdata[LOW-1:0];
            new_nxt_d  = '0;
            state_d    = ST_PATCH;
          end else begin
            roff_d  = '0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (!nxt_ok || hop_at_limit) begin
          err_d   = 1'b1;
          roff_d  = '0;
          rprev_d = cur_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          prev_d  = cur_q;
          cur_d   = rd_nxt;
          state_d = ST_READ;
        end
      end
      ST_PATCH: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        state_d = ST_NEWHDR;
      end
      ST_NEWHDR: begin
        mem_en     = 1'b1;
        mem_we     = 1'b1;
        mem_addr   = off_q[AW+1:2];
        wr_hdr.nxt = new_nxt_q;
        wr_hdr.ver = ver_q;
        wr_hdr.id  = id_q;
        roff_d     = off_q;
        done_d     = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_wdata = (state_q == ST_PATCH) ? {off_q, tail_low_q} : wr_hdr;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      prev_q     <= '0;
      new_nxt_q  <= '0;
      tail_low_q <= '0;
      done_q     <= 1'b0;
      found_q    <= 1'b0;
      err_q      <= 1'b0;
      roff_q     <= '0;
      rprev_q    <= '0;
    end else begin
      state_q    <= state_d;
      cur_q      <= cur_d;
      prev_q     <= prev_d;
      new_nxt_q  <= new_nxt_d;
      tail_low_q <= tail_low_d;
      done_q     <= done_d;
      found_q    <= found_d;
      err_q      <= err_d;
      roff_q     <= roff_d;
      rprev_q    <= rprev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      app_q <= 1'b0;
      id_q  <= '0;
      ver_q <= '0;
      off_q <= '0;
    end else if (load_cmd) begin
      app_q <= cmd_append;
      id_q  <= cmd_id;
      ver_q <= cmd_ver;
      off_q <= cmd_off;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign found    = found_q;
  assign err      = err_q;
  assign res_off  = roff_q;
  assign res_prev = rprev_q;
endmodule

// File: rtl/cap_chain_walker_chk.sv
module cap_chain_walker_chk #(
  parameter int unsigned LIST_BASE = 256,
  parameter int unsigned AW        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          found,
  input logic          err,
  input logic [11:0]   res_off,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_found_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (res_off >= 12'(LIST_BASE) && res_off[1:0] == 2'b00));

  assert_err_not_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !found);

  assert_write_in_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && busy));

  assert_read_in_list_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr >= AW'(LIST_BASE / 4)));

  assert_start_on_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
endmodule

bind cap_chain_walker cap_chain_walker_chk #(
  .LIST_BASE (LIST_BASE),
  .AW        ($clog2(CFG_BYTES) - 2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .found     (found),
  .err       (err),
  .res_off   (res_off),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/tb_cap_chain_walker.sv
`timescale 1ns/1ps
module tb_cap_chain_walker;
  localparam int CFG_BYTES = 4096;
  localparam int LIST_BASE = 256;
  localparam int HOP_LIMIT = 6;
  localparam int WORDS     = CFG_BYTES / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_append;
  logic [15:0] cmd_id;
  logic [3:0]  cmd_ver;
  logic [11:0] cmd_off;
  logic [12:0] cmd_size;
  logic        busy, done, found, err;
  logic [11:0] res_off, res_prev;
  logic        mem_en, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] ram     [0:WORDS-1];
  logic [31:0] ref_mem [0:WORDS-1];
  logic        ram_clr, pl_en;
  logic [9:0]  pl_addr;
  logic [31:0] pl_data;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cap_chain_walker #(.CFG_BYTES(CFG_BYTES), .LIST_BASE(LIST_BASE), .HOP_LIMIT(HOP_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
    .busy(busy), .done(done), .found(found), .err(err),
    .res_off(res_off), .res_prev(res_prev),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (ram_clr) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= '0;
    end else if (pl_en) begin
      ram[pl_addr] <= pl_data;
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  function automatic logic [31:0] hdr(input int id, input int ver, input int nxt);
    return {nxt[11:0], ver[3:0], id[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_space();
    @(negedge clk);
    ram_clr = 1'b1;
    @(negedge clk);
    ram_clr = 1'b0;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
  endtask

  task automatic put(input int off, input logic [31:0] h);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = off[11:2]; pl_data = h;
    @(negedge clk);
    pl_en = 1'b0;
    ref_mem[off / 4] = h;
  endtask

  // behavioural list walk over the bench's own copy of the space
  task automatic walk(input bit app, input int id, output bit f, output int o,
                      output int p, output bit e, output int k);
    int cur, prv, nx;
    logic [31:0] h;
    cur = LIST_BASE; prv = 0; f = 0; o = 0; p = 0; e = 0; k = 0;
    while (1) begin
      k++;
      h = ref_mem[cur / 4];
      if (!app && cur == LIST_BASE && h == 0) return;
      if (!app && int'(h[15:0]) == id) begin f = 1; o = cur; p = prv; return; end
      nx = int'(h[31:20]);
      if (nx == 0) begin p = cur; return; end
      if (nx % 4 != 0 || nx < LIST_BASE || nx > CFG_BYTES - 8 || k == HOP_LIMIT) begin
        e = 1; p = cur; return;
      end
      prv = cur; cur = nx;
    end
  endtask

  task automatic run(input bit app, input int id, input int ver, input int off,
                     input int size, input bit junk, input string req);
    bit ef, ee, bad;
    int eo, ep, k, lat, miss;
    logic [31:0] h;
    ef = 0; eo = 0; ep = 0; ee = 0;
    if (app) begin
      bad = (size < 8) || (off < LIST_BASE) || (off % 4 != 0) || (off + size > CFG_BYTES);
      if (bad) begin
        lat = 0; ee = 1;
      end else if (off == LIST_BASE) begin
        lat = 3; eo = off; ep = 0;
        h = ref_mem[LIST_BASE / 4];
        ref_mem[LIST_BASE / 4] = {h[31:20], ver[3:0], id[15:0]};
      end else begin
        walk(1'b1, id, ef, eo, ep, ee, k);
        if (ee) lat = 2 * k;
        else begin
          lat = 2 * k + 2; eo = off;
          h = ref_mem[ep / 4];
          ref_mem[ep / 4] = {off[11:0], h[19:0]};
          ref_mem[off / 4] = hdr(id, ver, 0);
        end
      end
    end else begin
      walk(1'b0, id, ef, eo, ep, ee, k);
      lat = 2 * k;
    end

    @(negedge clk);
    cmd_valid = 1'b1; cmd_append = app; cmd_id = id[15:0]; cmd_ver = ver[3:0];
    cmd_off = off[11:0]; cmd_size = size[12:0];
    @(posedge clk);
    for (int n = 0; n <= lat; n++) begin
      if (n > 0) @(posedge clk);
      @(negedge clk);
      if (n == 0) begin
        if (junk && lat >= 2) begin
          // R11: a second command while busy must be dropped
          cmd_valid = 1'b1; cmd_append = 1'b1; cmd_id = 16'h0055;
          cmd_off = 12'h400; cmd_size = 13'd16;
        end else cmd_valid = 1'b0;
      end else cmd_valid = 1'b0;
      chk(done === (n == lat), (n == lat) ? req : "R5", "done timing", int'(done), int'(n == lat));
      if (n < lat) chk(busy === 1'b1, "R5", "busy while working", int'(busy), 1);
    end
    chk(busy === 1'b0, "R5", "busy at done", int'(busy), 0);
    chk(err === ee, req, "err", int'(err), int'(ee));
    chk(found === ef, req, "found", int'(found), int'(ef));
    if (!ee) begin
      chk(int'(res_off) == eo, req, "res_off", int'(res_off), eo);
      chk(int'(res_prev) == ep, req, "res_prev", int'(res_prev), ep);
    end
    miss = 0;
    for (int i = 0; i < WORDS; i++) if (ram[i] !== ref_mem[i]) miss++;
    chk(miss == 0, req, "space contents mismatching words", miss, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_append = 1'b0; cmd_id = '0; cmd_ver = '0;
    cmd_off = '0; cmd_size = '0; ram_clr = 1'b0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R1", "outputs in reset",
        int'({busy, done, mem_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R1", "outputs after reset",
        int'({busy, done, mem_en}), 0);

    clear_space();
    run(1'b0, 1, 0, 0, 0, 1'b0, "R3");

    put(12'h100, hdr(1, 1, 12'h140));
    put(12'h140, hdr(2, 1, 12'h200));
    put(12'h200, hdr(3, 2, 0));
    run(1'b0, 2, 0, 0, 0, 1'b1, "R2");
    run(1'b0, 3, 0, 0, 0, 1'b0, "R2");
    run(1'b0, 1, 0, 0, 0, 1'b1, "R2");
    run(1'b0, 9, 0, 0, 0, 1'b0, "R4");

    run(1'b1, 5, 2, 12'h300, 16, 1'b1, "R8");
    run(1'b0, 5, 0, 0, 0, 1'b0, "R2");
    run(1'b1, 7, 3, 12'h100, 8, 1'b1, "R9");
    run(1'b0, 7, 0, 0, 0, 1'b0, "R9");

    run(1'b1, 8, 1, 12'h400, 4, 1'b0, "R10");
    run(1'b1, 8, 1, 12'h080, 8, 1'b0, "R10");
    run(1'b1, 8, 1, 12'hFF8, 16, 1'b0, "R10");
    run(1'b1, 8, 1, 12'h402, 8, 1'b0, "R10");
    run(1'b1, 8, 1, 12'hFF8, 8, 1'b0, "R10");
    run(1'b0, 8, 0, 0, 0, 1'b0, "R10");

    clear_space();
    put(12'h100, hdr(1, 1, 12'h142));
    run(1'b0, 2, 0, 0, 0, 1'b0, "R6");
    put(12'h100, hdr(1, 1, 12'h0F0));
    run(1'b0, 2, 0, 0, 0, 1'b0, "R6");
    put(12'h100, hdr(1, 1, 12'hFFC));
    run(1'b0, 2, 0, 0, 0, 1'b0, "R6");
    run(1'b1, 4, 1, 12'h500, 8, 1'b0, "R6");

    clear_space();
    for (int i = 0; i < HOP_LIMIT; i++)
      put(LIST_BASE + 16 * i, hdr(16 + i, 1, (i == HOP_LIMIT - 1) ? 0 : LIST_BASE + 16 * (i + 1)));
    run(1'b0, 99, 0, 0, 0, 1'b0, "R7");
    put(LIST_BASE + 16 * (HOP_LIMIT - 1), hdr(16 + HOP_LIMIT - 1, 1, LIST_BASE + 16 * HOP_LIMIT));
    put(LIST_BASE + 16 * HOP_LIMIT, hdr(60, 1, 0));
    run(1'b0, 99, 0, 0, 0, 1'b0, "R7");
    clear_space();
    put(12'h100, hdr(1, 1, 12'h100));
    run(1'b0, 2, 0, 0, 0, 1'b1, "R7");

    summary();
  end
endmodule